// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle Detection and Address Wakeup

This block is the receive side of an asynchronous serial link. A baud enable pulse at sixteen times the bit rate drives an internal sampler. The sampler waits for a falling edge on the line, confirms the start bit at its midpoint, and then reads each data bit and the stop bit at their centres. Each character is delivered with a one-cycle strobe. A parity error flag and a framing error flag are delivered with the character.

Two controls set the character shape. A length control selects eight or nine data bits. A parity control turns the highest data bit into a parity bit, so seven or eight bits remain for user data, and a second control chooses odd or even parity. After a complete character the block counts high bit-times on the line and raises an idle flag once a full frame length of ones has passed. A sleep request makes the receiver drop characters until one arrives with its ninth data bit set. That address character wakes the receiver and is delivered.

Top module: `serial_rx`

## Requirements
- R1: With `mode9` low, a frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. `rx_data[7:0]` holds the data and `rx_data[8]` reads 0.
- R2: With `mode9` high, a frame carries nine data bits, least significant bit first, and all nine appear on `rx_data[8:0]`.
- R3: With `par_en` high, the last data bit before the stop bit is parity. `rx_data` then holds 7 user bits (`mode9` low) or 8 user bits (`mode9` high), and the position of the parity bit and every bit above it read 0.
- R4: Odd parity (`par_odd`=1) expects a parity bit of 1 when the user data has an even number of ones. Even parity expects 0 in that case. A mismatch sets `par_err` with the character.
- R5: A stop bit sampled low sets `frm_err`, and the character is still delivered.
- R6: `rx_valid` lasts one clock cycle. `rx_data`, `par_err` and `frm_err` change only on a cycle where `rx_valid` is high, and they hold until the next `rx_valid`.
- R7: A low on the line that has returned high by the middle of the start bit is a false start and produces no `rx_valid`.
- R8: After a complete frame, `idle` rises once the line has stayed high for 10 bit-times (`mode9` low) or 11 bit-times (`mode9` high) past the end of the stop bit. It falls when the line goes low.
- R9: The idle count starts only after a complete frame. After reset, a high line with no frame never raises `idle`, and the value of the last character does not change when `idle` rises.
- R10: A one-cycle `wake_req` sets `asleep`. While `asleep` is high, a frame whose ninth data bit is 0 (any frame with `mode9` low) produces no `rx_valid` and leaves `rx_data`, `par_err` and `frm_err` unchanged.
- R11: While asleep, a `mode9` frame with its ninth data bit set clears `asleep` and is delivered. Frames that follow are delivered normally.
- R12: After reset, `rx_valid`, `rx_data`, `par_err`, `frm_err`, `idle` and `asleep` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idles high |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| mode9 | input | 1 | 1: nine data bits per frame, 0: eight |
| par_en | input | 1 | 1: top data bit is parity |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| wake_req | input | 1 | One-cycle request to enter sleep |
| rx_data | output | 9 | Received user data, zero-extended |
| rx_valid | output | 1 | One-cycle strobe for a delivered character |
| par_err | output | 1 | Parity mismatch on the last delivered character |
| frm_err | output | 1 | Stop bit low on the last delivered character |
| idle | output | 1 | Line idle after a complete frame |
| asleep | output | 1 | Receiver is discarding frames |

## Verification
Characters are sent in both lengths, with parity off and with both parity senses, and with data values whose ones counts are odd and even. This separates a parity bit that is computed wrongly from one taken from the wrong position. The bench also sends an all-ones character in eight-bit mode to show that the top data bit is masked and that ones in the data do not shorten the idle wait. Idle is sampled half a bit-time before and half a bit-time after the expected threshold in each mode, so an off-by-one bit count is caught. A short low glitch separates a real start bit from a false one. In the sleep sequence, a non-address frame is sent after an errored character, so any discarded frame that leaks through would change the held flags.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
package serial_rx_pkg;
  localparam int OVS_DEF   = 16;
  localparam int FIELD_DEF = 9;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rst_n_q,
  output logic line_q
);
  logic [1:0] rst_pipe;
  logic [1:0] line_pipe;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_pipe <= 2'b11;
    else        line_pipe <= {line_pipe[0], line_in};
  end

  assign rst_n_q = rst_pipe[1];
  assign line_q  = line_pipe[1];
endmodule

// File: rtl/rx_framer.sv
`timescale 1ns/1ps
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OVS     = OVS_DEF,
  parameter int FIELD_W = FIELD_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               line,
  input  logic               mode9,
  output logic               frame_done,
  output logic [FIELD_W-1:0] field,
  output logic               stop_ok,
  output logic               frame_m9,
  output logic               in_hunt
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(FIELD_W + 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rx_state_e          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BIT_W-1:0]   bitn_q, bitn_d;
  logic [FIELD_W-1:0] sh_q, sh_d;
  logic               m9_q, m9_d;
  logic               done_q, done_d;
  logic               stop_q, stop_d;
  logic [BIT_W-1:0]   bit_last;

  assign bit_last = m9_q ? BIT_W'(FIELD_W - 1) : BIT_W'(FIELD_W - 2);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bitn_d = bitn_q;
    sh_d   = sh_q;
    m9_d   = m9_q;
    stop_d = stop_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (tick && !line) begin
          st_d  = ST_START;
          cnt_d = '0;
          m9_d  = mode9;
        end
      end
      ST_START: begin
        if (tick) begin
          if (cnt_q == HALF) begin
            cnt_d  = '0;
            bitn_d = '0;
            st_d   = line ? ST_HUNT : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick) begin
          if (cnt_q == LAST) begin
            cnt_d  = '0;
            sh_d   = {line, sh_q[FIELD_W-1:1]};
            bitn_d = bitn_q + 1'b1;
            if (bitn_q == bit_last) st_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          if (cnt_q == LAST) begin
            cnt_d  = '0;
            st_d   = ST_HUNT;
            stop_d = line;
            done_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      cnt_q  <= '0;
      bitn_q <= '0;
      sh_q   <= '0;
      m9_q   <= 1'b0;
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bitn_q <= bitn_d;
      sh_q   <= sh_d;
      m9_q   <= m9_d;
      done_q <= done_d;
      stop_q <= stop_d;
    end
  end

  // an eight-bit field sits in the upper bits of the shifter
  assign field      = m9_q ? sh_q : (sh_q >> 1);
  assign frame_done = done_q;
  assign stop_ok    = stop_q;
  assign frame_m9   = m9_q;
  assign in_hunt    = (st_q == ST_HUNT);
endmodule

// File: rtl/rx_idle.sv
`timescale 1ns/1ps
module rx_idle #(
  parameter int OVS     = 16,
  parameter int FIELD_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic in_hunt,
  input  logic frame_done,
  input  logic mode9,
  output logic idle
);
  // ticks from the stop-bit sample: half a bit, then a full frame of ones
  localparam int LIM_LONG  = OVS / 2 + OVS * (FIELD_W + 2);
  localparam int LIM_SHORT = OVS / 2 + OVS * (FIELD_W + 1);
  localparam int CW        = $clog2(LIM_LONG + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] thr;
  logic          armed_q, armed_d;
  logic          idle_q, idle_d;

  assign thr = mode9 ? CW'(LIM_LONG) : CW'(LIM_SHORT);

  always_comb begin
    armed_d = armed_q | frame_done;
    cnt_d   = cnt_q;
    if (!in_hunt || !line)            cnt_d = '0;
    else if (tick && (cnt_q < thr))   cnt_d = cnt_q + 1'b1;
    idle_d  = armed_q && in_hunt && line && (cnt_q >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      idle_q  <= idle_d;
    end
  end

  assign idle = idle_q;
endmodule

// File: rtl/rx_deliver.sv
`timescale 1ns/1ps
module rx_deliver #(
  parameter int FIELD_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic [FIELD_W-1:0] field,
  input  logic               stop_ok,
  input  logic               frame_m9,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               asleep,
  output logic [FIELD_W-1:0] rx_data,
  output logic               rx_valid,
  output logic               par_err,
  output logic               frm_err,
  output logic               wake_hit
);
  localparam int IDX_W = $clog2(FIELD_W + 1);

  logic [IDX_W-1:0]   uw;
  logic [FIELD_W-1:0] data_w;
  logic               par_rx, par_exp, mism, addr, accept;

  logic [FIELD_W-1:0] data_q, data_d;
  logic               valid_q, valid_d;
  logic               perr_q, perr_d;
  logic               ferr_q, ferr_d;

  always_comb begin
    uw = IDX_W'(FIELD_W) - {{(IDX_W-1){1'b0}}, ~frame_m9}
                         - {{(IDX_W-1){1'b0}}, par_en};
    par_rx = 1'b0;
    for (int i = 0; i < FIELD_W; i++) begin
      data_w[i] = field[i] & (IDX_W'(i) < uw);
      par_rx    = par_rx | (field[i] & (IDX_W'(i) == uw));
    end
    par_exp = par_odd ? ~(^data_w) : (^data_w);
    mism    = par_en && (par_rx != par_exp);
    addr    = frame_m9 && field[FIELD_W-1];
    accept  = frame_done && (!asleep || addr);

    valid_d = accept;
    data_d  = data_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    if (accept) begin
      data_d = data_w;
      perr_d = mism;
      ferr_d = ~stop_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;
  assign par_err  = perr_q;
  assign frm_err  = ferr_q;
  assign wake_hit = frame_done && asleep && addr;
endmodule

// File: rtl/serial_rx.sv
`timescale 1ns/1ps
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int OVS     = OVS_DEF,
  parameter int FIELD_W = FIELD_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_line,
  input  logic               baud_tick,
  input  logic               mode9,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               wake_req,
  output logic [FIELD_W-1:0] rx_data,
  output logic               rx_valid,
  output logic               par_err,
  output logic               frm_err,
  output logic               idle,
  output logic               asleep
);
  logic               rst_i, line_s;
  logic               done, stop_ok, fm9, hunt, wake_hit;
  logic [FIELD_W-1:0] field;
  logic               sleep_q, sleep_d;

  rx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(rx_line),
    .rst_n_q(rst_i), .line_q(line_s)
  );

  rx_framer #(.OVS(OVS), .FIELD_W(FIELD_W)) u_framer (
    .clk(clk), .rst_n(rst_i), .tick(baud_tick), .line(line_s), .mode9(mode9),
    .frame_done(done), .field(field), .stop_ok(stop_ok),
    .frame_m9(fm9), .in_hunt(hunt)
  );

  rx_idle #(.OVS(OVS), .FIELD_W(FIELD_W)) u_idle (
    .clk(clk), .rst_n(rst_i), .tick(baud_tick), .line(line_s),
    .in_hunt(hunt), .frame_done(done), .mode9(mode9), .idle(idle)
  );

  rx_deliver #(.FIELD_W(FIELD_W)) u_deliver (
    .clk(clk), .rst_n(rst_i), .frame_done(done), .field(field),
    .stop_ok(stop_ok), .frame_m9(fm9), .par_en(par_en), .par_odd(par_odd),
    .asleep(sleep_q), .rx_data(rx_data), .rx_valid(rx_valid),
    .par_err(par_err), .frm_err(frm_err), .wake_hit(wake_hit)
  );

  always_comb begin
    sleep_d = sleep_q;
    if (wake_req)      sleep_d = 1'b1;
    else if (wake_hit) sleep_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sleep_q <= 1'b0;
    else        sleep_q <= sleep_d;
  end

  assign asleep = sleep_q;
endmodule

// File: rtl/serial_rx_chk.sv
`timescale 1ns/1ps
module serial_rx_chk #(
  parameter int FIELD_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_line,
  input logic               baud_tick,
  input logic               mode9,
  input logic               par_en,
  input logic               par_odd,
  input logic               wake_req,
  input logic [FIELD_W-1:0] rx_data,
  input logic               rx_valid,
  input logic               par_err,
  input logic               frm_err,
  input logic               idle,
  input logic               asleep
);
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(par_err) && $stable(frm_err)));

  a_r1_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !mode9) |-> !rx_data[FIELD_W-1]);

  a_r3_parity_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && par_en) |-> !rx_data[FIELD_W-1]);

  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !rx_valid);

  a_r10_sleep_set: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> asleep);

  a_r11_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(asleep) && !$past(wake_req)) |-> !asleep);
endmodule

bind serial_rx serial_rx_chk #(.FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/serial_rx_test.sv
`timescale 1ns/1ps
module serial_rx_test;
  localparam int BITCLK = 64;  // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rst_n, rx_line, baud_tick, mode9, par_en, par_odd, wake_req;
  logic [8:0] rx_data;
  logic       rx_valid, par_err, frm_err, idle, asleep;
  logic [1:0] tcnt = 2'd0;

  int checks = 0;
  int fails  = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign baud_tick = (tcnt == 2'd3);

  serial_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
    .mode9(mode9), .par_en(par_en), .par_odd(par_odd), .wake_req(wake_req),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err),
    .frm_err(frm_err), .idle(idle), .asleep(asleep)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic pbit(input logic [8:0] d, input logic odd);
    return odd ? ~(^d) : (^d);
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rx_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 R10 unexpected rx_valid",
                {21'd0, frm_err, par_err, rx_data}, 32'd0);
        end else begin
          logic [10:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({frm_err, par_err, rx_data} == e, t,
                {21'd0, frm_err, par_err, rx_data}, {21'd0, e});
        end
      end
    end
  end

  task automatic bit_time(input logic v);
    rx_line = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic hold_high(input int bits);
    rx_line = 1'b1;
    repeat (bits * BITCLK) @(negedge clk);
  endtask

  // drive one frame; bad_stop holds the stop low for 12 of its 16 ticks
  task automatic tx(input logic m9, input logic pe, input logic odd,
                    input logic [8:0] d, input logic bad_par,
                    input logic bad_stop, input logic deliver, input string tag);
    int nb, uw;
    logic [8:0] dm, fld;
    mode9 = m9; par_en = pe; par_odd = odd;
    nb = m9 ? 9 : 8;
    uw = nb - (pe ? 1 : 0);
    dm = d & 9'((1 << uw) - 1);
    fld = dm;
    if (pe) fld[uw] = pbit(dm, odd) ^ bad_par;
    if (deliver) begin
      exp_q.push_back({bad_stop, pe & bad_par, dm});
      tag_q.push_back(tag);
    end
    bit_time(1'b0);
    for (int i = 0; i < nb; i++) bit_time(fld[i]);
    if (bad_stop) begin
      rx_line = 1'b0;
      repeat (48) @(negedge clk);
      rx_line = 1'b1;
      repeat (16) @(negedge clk);
    end else begin
      bit_time(1'b1);
    end
  endtask

  initial begin
    rst_n = 1'b0; rx_line = 1'b1; mode9 = 1'b0; par_en = 1'b0;
    par_odd = 1'b0; wake_req = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({rx_valid, rx_data, par_err, frm_err, idle, asleep} == 14'd0,
          "R12 reset state",
          {18'd0, rx_valid, rx_data, par_err, frm_err, idle, asleep}, 32'd0);

    // R9: no frame yet, idle must stay low
    hold_high(13);
    check(idle == 1'b0, "R9 no idle before any frame", idle, 0);

    // R1: eight-bit frames
    tx(0, 0, 0, 9'h0A5, 0, 0, 1, "R1 data 0xA5");
    hold_high(2);
    tx(0, 0, 0, 9'h03C, 0, 0, 1, "R1 data 0x3C");
    hold_high(2);
    // all ones character, top bit masked; then R8 and R9 idle timing
    tx(0, 0, 0, 9'h1FF, 0, 0, 1, "R1 data 0xFF");
    repeat (9 * BITCLK + BITCLK / 2) @(negedge clk);
    check(idle == 1'b0, "R8 idle early, 8-bit mode", idle, 0);
    repeat (BITCLK) @(negedge clk);
    check(idle == 1'b1, "R8 R9 idle after 10 bits", idle, 1);

    // R7 false start, R8 idle clears on low
    rx_line = 1'b0;
    repeat (12) @(negedge clk);
    check(idle == 1'b0, "R8 idle clears on low line", idle, 0);
    rx_line = 1'b1;
    hold_high(3);

    // R2: nine-bit frames and R8 long threshold
    tx(1, 0, 0, 9'h1A5, 0, 0, 1, "R2 data 0x1A5");
    hold_high(2);
    tx(1, 0, 0, 9'h05A, 0, 0, 1, "R2 data 0x05A");
    repeat (10 * BITCLK + BITCLK / 2) @(negedge clk);
    check(idle == 1'b0, "R8 idle early, 9-bit mode", idle, 0);
    repeat (BITCLK) @(negedge clk);
    check(idle == 1'b1, "R8 idle after 11 bits", idle, 1);

    // R3 and R4: parity
    tx(0, 1, 0, 9'h053, 0, 0, 1, "R3 R4 even parity 7-bit");
    hold_high(2);
    tx(0, 1, 1, 9'h053, 0, 0, 1, "R4 odd parity 7-bit");
    hold_high(2);
    tx(1, 1, 1, 9'h0C1, 0, 0, 1, "R3 R4 odd parity 8-bit");
    hold_high(2);
    tx(1, 1, 0, 9'h0C7, 0, 0, 1, "R4 even parity 8-bit");
    hold_high(2);
    tx(0, 1, 0, 9'h031, 1, 0, 1, "R4 parity mismatch");
    hold_high(3);
    check(par_err == 1'b1, "R6 par_err held", par_err, 1);
    tx(0, 1, 0, 9'h031, 0, 0, 1, "R6 par_err cleared");
    hold_high(2);

    // R5: framing error
    tx(0, 0, 0, 9'h066, 0, 1, 1, "R5 framing error delivered");
    hold_high(3);
    check(frm_err == 1'b1, "R6 frm_err held", frm_err, 1);
    tx(0, 0, 0, 9'h099, 0, 0, 1, "R6 frm_err cleared");
    hold_high(2);

    // R10 and R11: sleep and address wakeup
    tx(1, 0, 0, 9'h011, 0, 1, 1, "R10 setup frame");
    hold_high(2);
    @(negedge clk); wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
    check(asleep == 1'b1, "R10 asleep set", asleep, 1);
    tx(1, 0, 0, 9'h0F0, 0, 0, 0, "R10 dropped");
    hold_high(2);
    check({frm_err, rx_data} == 10'h211, "R10 outputs unchanged",
          {22'd0, frm_err, rx_data}, 32'h211);
    check(asleep == 1'b1, "R10 still asleep", asleep, 1);
    tx(0, 0, 0, 9'h0FF, 0, 0, 0, "R10 8-bit dropped");
    hold_high(2);
    tx(1, 0, 0, 9'h1C3, 0, 0, 1, "R11 address frame");
    hold_high(1);
    check(asleep == 1'b0, "R11 asleep cleared", asleep, 0);
    tx(1, 0, 0, 9'h022, 0, 0, 1, "R11 normal after wake");
    hold_high(3);

    check(exp_q.size() == 0, "R1 R2 all expected frames delivered",
          exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule